// File: doc/BRIEF.md
# Channel FIFO Event Interrupt Controller

This block gathers status events from a set of channel FIFOs and turns them into one interrupt line for a processor. Each channel reports six kinds of event as single-cycle pulses: almost-empty, almost-full and overflow, each for its capture direction and its playback direction. Every pulse sets a sticky pending bit. Software reads the pending bits, enables the ones it cares about, and clears them by writing ones.

Each channel owns an eight-bit lane in a 32-bit register word called a bank. Four channels share a bank, so ten channels need three banks. Each bank has four views with the same bit layout: enable, write-one-to-clear, raw pending and masked pending. A separate gate word with one bit per channel decides which channels can drive the processor interrupt. The output is registered.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every enable, raw, masked and gate register reads zero and `irq_o` is 0.
- R2: A pulse on `ev_i[ch*6+code]` sets the raw pending bit at bit position `8*(ch%4)+code` of bank `ch/4` at the next clock edge, whether or not that bit is enabled. The event codes are: capture almost-empty 0, capture almost-full 1, playback almost-empty 2, playback almost-full 3, capture overflow 4, playback overflow 5.
- R3: Writing the clear view with a one at a bit position clears that raw pending bit. Zero bits leave the raw bits unchanged. The clear view always reads 0.
- R4: If an event pulse and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R5: The enable view can be read and written, and stores only bits 0 to 5 of each lane. The masked view equals raw AND enable.
- R6: `irq_o` is 1 one cycle after any masked pending bit of a channel whose gate bit is set, and 0 one cycle after no such bit exists.
- R7: The gate word holds bit `ch` for channel `ch`. Only the low ten bits are stored. It can be read and written.
- R8: Addressing uses `addr[4:2]` to select the view (0 enable, 1 clear, 2 raw, 3 masked, 4 gate) and `addr[1:0]` to select the bank; the gate view ignores the bank field. Banks beyond the last one, lanes with no channel behind them, and view codes 5 to 7 read 0, and writes to them are ignored.
- R9: Pulses on several channels and banks in the same cycle are each kept in their own lane without disturbing the other lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_i | input | 60 | Event pulses; bit ch*6+code |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address {view, bank} |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read address {view, bank} |
| rd_data | output | 32 | Combinational read data |
| irq_o | output | 1 | Registered processor interrupt |

## Verification
Single pulses are placed in channels in different bank positions (first slot, second slot, last slot, and the partly filled third bank), so a wrong lane base or bank number moves the bit where the readback exposes it. Clear writes with only zeros at the pending position are compared with writes that carry a one there. A pulse and a clear on the same bit in the same cycle show which one wins. With the enable bit set, the gate bit is switched between the channel's own bit and another channel's bit, so the interrupt line shows whether the gate is decoded per channel. Writes to a bank that does not exist and to lanes with no channel behind them confirm that nothing is stored.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;

    localparam int EV_N        = 6;
    localparam int LANE_W      = 8;
    localparam int CH_PER_BANK = 4;
    localparam int WORD_W      = LANE_W * CH_PER_BANK;
    localparam int KIND_W      = 3;
    localparam int BANK_AW     = 2;
    localparam int ADDR_W      = KIND_W + BANK_AW;
    localparam int BANK_SLOTS  = 1 << BANK_AW;

    typedef enum logic [KIND_W-1:0] {
        KIND_EN  = 3'd0,
        KIND_CLR = 3'd1,
        KIND_RAW = 3'd2,
        KIND_MSK = 3'd3,
        KIND_CPU = 3'd4
    } reg_kind_e;

    typedef enum logic [2:0] {
        EV_CAP_AE  = 3'd0,
        EV_CAP_AF  = 3'd1,
        EV_PLY_AE  = 3'd2,
        EV_PLY_AF  = 3'd3,
        EV_CAP_OVF = 3'd4,
        EV_PLY_OVF = 3'd5
    } ev_code_e;

    typedef struct packed {
        logic [KIND_W-1:0]  kind;
        logic [BANK_AW-1:0] bank;
    } reg_addr_t;

    function automatic reg_addr_t split_addr(input logic [ADDR_W-1:0] a);
        return reg_addr_t'(a);
    endfunction

    function automatic int bank_of(input int ch);
        return ch / CH_PER_BANK;
    endfunction

    function automatic int lane_lsb(input int ch);
        return (ch % CH_PER_BANK) * LANE_W;
    endfunction

endpackage

// File: rtl/fifo_irq_lane.sv
module fifo_irq_lane
    import fifo_irq_pkg::*;
#(
    parameter int EVN = EV_N
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [EVN-1:0] ev_i,
    input  logic           en_we,
    input  logic           clr_we,
    input  logic [EVN-1:0] wdata,
    input  logic           gate_i,
    output logic [EVN-1:0] en_o,
    output logic [EVN-1:0] raw_o,
    output logic [EVN-1:0] msk_o,
    output logic           req_o
);

    logic [EVN-1:0] en_q;
    logic [EVN-1:0] raw_q;
    logic [EVN-1:0] clr_bits;

    assign clr_bits = clr_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            raw_q <= '0;
        end else begin
            if (en_we)
                en_q <= wdata;
            // a new event outranks a clear of the same bit
            raw_q <= (raw_q & ~clr_bits) | ev_i;
        end
    end

    assign en_o  = en_q;
    assign raw_o = raw_q;
    assign msk_o = raw_q & en_q;
    assign req_o = gate_i & (|msk_o);

endmodule

// File: rtl/fifo_irq_regfile.sv
module fifo_irq_regfile
    import fifo_irq_pkg::*;
#(
    parameter int NUM_CH = 10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [WORD_W-1:0]      wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [NUM_CH*EV_N-1:0] en_flat,
    input  logic [NUM_CH*EV_N-1:0] raw_flat,
    input  logic [NUM_CH*EV_N-1:0] msk_flat,
    output logic [NUM_CH-1:0]      en_we,
    output logic [NUM_CH-1:0]      clr_we,
    output logic [NUM_CH*EV_N-1:0] lane_wdata,
    output logic [NUM_CH-1:0]      cpu_mask,
    output logic [WORD_W-1:0]      rd_data
);

    localparam int NUM_BANK = (NUM_CH + CH_PER_BANK - 1) / CH_PER_BANK;

    reg_addr_t wa;
    reg_addr_t ra;
    logic [WORD_W-1:0] en_word  [BANK_SLOTS];
    logic [WORD_W-1:0] raw_word [BANK_SLOTS];
    logic [WORD_W-1:0] msk_word [BANK_SLOTS];
    logic unused_wbits;

    assign wa = split_addr(wr_addr);
    assign ra = split_addr(rd_addr);
    assign unused_wbits = ^wr_data;

    // write decode: one strobe pair and one data slice per channel
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_wdec
        localparam logic [BANK_AW-1:0] MY_BANK = BANK_AW'(bank_of(ch));
        localparam int LSB = lane_lsb(ch);
        logic hit;
        assign hit = wr_en && (wa.bank == MY_BANK);
        assign en_we[ch]  = hit && (wa.kind == KIND_EN);
        assign clr_we[ch] = hit && (wa.kind == KIND_CLR);
        assign lane_wdata[ch*EV_N +: EV_N] = wr_data[LSB +: EV_N];
    end

    always_ff @(posedge clk) begin
        if (rst)
            cpu_mask <= '0;
        else if (wr_en && wa.kind == KIND_CPU)
            cpu_mask <= wr_data[NUM_CH-1:0];
    end

    // pack per-channel vectors into bank words; empty lanes stay zero
    always_comb begin
        for (int b = 0; b < BANK_SLOTS; b++) begin
            en_word[b]  = '0;
            raw_word[b] = '0;
            msk_word[b] = '0;
        end
        for (int ch = 0; ch < NUM_CH; ch++) begin
            en_word[bank_of(ch)][lane_lsb(ch) +: EV_N]  = en_flat[ch*EV_N +: EV_N];
            raw_word[bank_of(ch)][lane_lsb(ch) +: EV_N] = raw_flat[ch*EV_N +: EV_N];
            msk_word[bank_of(ch)][lane_lsb(ch) +: EV_N] = msk_flat[ch*EV_N +: EV_N];
        end
    end

    always_comb begin
        rd_data = '0;
        case (ra.kind)
            KIND_EN:  if (int'(ra.bank) < NUM_BANK) rd_data = en_word[ra.bank];
            KIND_RAW: if (int'(ra.bank) < NUM_BANK) rd_data = raw_word[ra.bank];
            KIND_MSK: if (int'(ra.bank) < NUM_BANK) rd_data = msk_word[ra.bank];
            KIND_CPU: rd_data = WORD_W'(cpu_mask);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
    import fifo_irq_pkg::*;
#(
    parameter int NUM_CH = 10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_CH*EV_N-1:0] ev_i,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [WORD_W-1:0]      wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [WORD_W-1:0]      rd_data,
    output logic                   irq_o
);

    localparam int EVW = NUM_CH * EV_N;

    logic [EVW-1:0]    en_flat;
    logic [EVW-1:0]    raw_flat;
    logic [EVW-1:0]    msk_flat;
    logic [EVW-1:0]    lane_wdata;
    logic [NUM_CH-1:0] en_we;
    logic [NUM_CH-1:0] clr_we;
    logic [NUM_CH-1:0] cpu_mask;
    logic [NUM_CH-1:0] ch_req;
    logic              irq_q;

    fifo_irq_regfile #(.NUM_CH(NUM_CH)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .en_flat    (en_flat),
        .raw_flat   (raw_flat),
        .msk_flat   (msk_flat),
        .en_we      (en_we),
        .clr_we     (clr_we),
        .lane_wdata (lane_wdata),
        .cpu_mask   (cpu_mask),
        .rd_data    (rd_data)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        fifo_irq_lane #(.EVN(EV_N)) lane_i (
            .clk    (clk),
            .rst    (rst),
            .ev_i   (ev_i[ch*EV_N +: EV_N]),
            .en_we  (en_we[ch]),
            .clr_we (clr_we[ch]),
            .wdata  (lane_wdata[ch*EV_N +: EV_N]),
            .gate_i (cpu_mask[ch]),
            .en_o   (en_flat[ch*EV_N +: EV_N]),
            .raw_o  (raw_flat[ch*EV_N +: EV_N]),
            .msk_o  (msk_flat[ch*EV_N +: EV_N]),
            .req_o  (ch_req[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= |ch_req;
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/fifo_irq_ctrl_chk.sv
module fifo_irq_ctrl_chk
    import fifo_irq_pkg::*;
#(
    parameter int NUM_CH = 10
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NUM_CH*EV_N-1:0] ev_i,
    input logic                   wr_en,
    input logic [ADDR_W-1:0]      wr_addr,
    input logic [NUM_CH*EV_N-1:0] raw_q,
    input logic [NUM_CH*EV_N-1:0] en_q,
    input logic [NUM_CH-1:0]      cpu_mask,
    input logic                   irq_o
);

    logic [NUM_CH*EV_N-1:0] gated;
    logic clr_wr;
    logic cpu_wr;

    always_comb begin
        for (int ch = 0; ch < NUM_CH; ch++)
            gated[ch*EV_N +: EV_N] = raw_q[ch*EV_N +: EV_N] & en_q[ch*EV_N +: EV_N]
                                     & {EV_N{cpu_mask[ch]}};
    end

    assign clr_wr = wr_en && (wr_addr[ADDR_W-1 -: KIND_W] == 3'd1);
    assign cpu_wr = wr_en && (wr_addr[ADDR_W-1 -: KIND_W] == 3'd4);

    // R2
    ev_sets_raw_chk: assert property (@(posedge clk) disable iff (rst)
        (|ev_i) |=> ((raw_q & $past(ev_i)) == $past(ev_i)));

    // R3
    raw_fall_needs_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (|($past(raw_q) & ~raw_q)) |-> $past(clr_wr));

    // R4
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && |ev_i) |=> ((raw_q & $past(ev_i)) == $past(ev_i)));

    // R6
    irq_rises_chk: assert property (@(posedge clk) disable iff (rst)
        (|gated) |=> irq_o);

    // R6
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(|gated) |=> !irq_o);

    // R7
    gate_write_only_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_mask != $past(cpu_mask)) |-> $past(cpu_wr));

endmodule

bind fifo_irq_ctrl fifo_irq_ctrl_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .ev_i     (ev_i),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .raw_q    (raw_flat),
    .en_q     (en_flat),
    .cpu_mask (cpu_mask),
    .irq_o    (irq_o)
);

// File: tb/fifo_irq_ctrl_tb_top.sv
module fifo_irq_ctrl_tb_top;
    import fifo_irq_pkg::*;

    localparam int NCH = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH*6-1:0]  ev_i = '0;
    logic              wr_en = 1'b0;
    logic [4:0]        wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [4:0]        rd_addr = '0;
    logic [31:0]       rd_data;
    logic              irq_o;

    int checks = 0;
    int errors = 0;
    int pending = 0;
    bit finished = 0;

    typedef struct {
        bit          is_irq;
        logic [4:0]  addr;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #5 clk = ~clk;

    fifo_irq_ctrl #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst(rst), .ev_i(ev_i), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
    );

    function automatic logic [4:0] ad(input int kind, input int bank);
        return 5'((kind << 2) | bank);
    endfunction

    // monitor: pops expected items and compares against the design
    initial begin
        forever begin
            sb_item_t it;
            wait (sb_q.size() != 0);
            @(negedge clk);
            it = sb_q.pop_front();
            rd_addr = it.addr;
            #1;
            checks++;
            if (it.is_irq) begin
                if (irq_o !== it.exp[0]) begin
                    errors++;
                    $display("FAIL %s irq_o actual %0b expected %0b", it.tag, irq_o, it.exp[0]);
                end
            end else if (rd_data !== it.exp) begin
                errors++;
                $display("FAIL %s addr %0h actual %08h expected %08h", it.tag, it.addr, rd_data, it.exp);
            end
            pending--;
        end
    end

    task automatic exp_rd(input int kind, input int bank, input logic [31:0] e, input string tag);
        sb_item_t it;
        it.is_irq = 0; it.addr = ad(kind, bank); it.exp = e; it.tag = tag;
        pending++;
        sb_q.push_back(it);
    endtask

    task automatic exp_irq(input bit e, input string tag);
        sb_item_t it;
        it.is_irq = 1; it.addr = '0; it.exp = {31'd0, e}; it.tag = tag;
        pending++;
        sb_q.push_back(it);
    endtask

    task automatic sync();
        wait (pending == 0);
    endtask

    task automatic wr(input int kind, input int bank, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ad(kind, bank); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [NCH*6-1:0] bits);
        @(negedge clk);
        ev_i = bits;
        @(negedge clk);
        ev_i = '0;
    endtask

    task automatic pulse_and_clear(input logic [NCH*6-1:0] bits, input int bank, input logic [31:0] d);
        @(negedge clk);
        ev_i = bits; wr_en = 1'b1; wr_addr = ad(1, bank); wr_data = d;
        @(negedge clk);
        ev_i = '0; wr_en = 1'b0;
    endtask

    function automatic logic [NCH*6-1:0] evb(input int ch, input ev_code_e code);
        logic [NCH*6-1:0] v = '0;
        v[ch*6 + int'(code)] = 1'b1;
        return v;
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int b = 0; b < 3; b++) begin
            exp_rd(0, b, 32'h0, "R1 enable reset");
            exp_rd(2, b, 32'h0, "R1 raw reset");
            exp_rd(3, b, 32'h0, "R1 masked reset");
        end
        exp_rd(4, 0, 32'h0, "R1 gate reset");
        exp_irq(1'b0, "R1 irq reset");
        sync();

        // R2 channel 5 capture overflow -> bank1 bit 12, enable off
        pulse(evb(5, EV_CAP_OVF));
        exp_rd(2, 1, 32'h0000_1000, "R2 raw set without enable");
        exp_rd(3, 1, 32'h0, "R5 masked with enable off");
        exp_rd(2, 0, 32'h0, "R2 other bank untouched");
        sync();

        // R5 enable stores bits 0..5 per lane
        wr(0, 1, 32'hFFFF_FFFF);
        exp_rd(0, 1, 32'h3F3F_3F3F, "R5 enable readback");
        exp_rd(3, 1, 32'h0000_1000, "R5 masked = raw & enable");
        exp_irq(1'b0, "R6 irq gated off by mask");
        sync();

        // R7 gate word width, then gate channel 5
        wr(4, 0, 32'hFFFF_FFFF);
        exp_rd(4, 0, 32'h0000_03FF, "R7 gate width");
        sync();
        wr(4, 2, 32'h0000_0020);
        exp_rd(4, 0, 32'h0000_0020, "R7 gate ignores bank field");
        exp_irq(1'b1, "R6 irq raised for gated channel");
        sync();

        // R3 zeros at the pending bit do nothing
        wr(1, 1, 32'hFFFF_EFFF);
        exp_rd(2, 1, 32'h0000_1000, "R3 zero clear bit no effect");
        exp_rd(1, 1, 32'h0, "R3 clear view reads zero");
        exp_irq(1'b1, "R6 irq held");
        sync();
        wr(1, 1, 32'h0000_1000);
        exp_rd(2, 1, 32'h0, "R3 one clears pending");
        exp_irq(1'b0, "R6 irq drops after clear");
        sync();

        // R4 set and clear together
        pulse_and_clear(evb(5, EV_CAP_OVF), 1, 32'h0000_1000);
        exp_rd(2, 1, 32'h0000_1000, "R4 set wins over clear");
        sync();
        wr(1, 1, 32'h0000_1000);
        exp_rd(2, 1, 32'h0, "R4 later clear works");
        sync();

        // R9 several channels at once
        pulse(evb(9, EV_PLY_OVF) | evb(0, EV_CAP_AF) | evb(3, EV_PLY_AE));
        exp_rd(2, 0, 32'h0400_0002, "R9 bank0 lanes 0 and 3");
        exp_rd(2, 2, 32'h0000_2000, "R9 bank2 lane 1");
        exp_rd(2, 1, 32'h0, "R9 bank1 untouched");
        sync();

        // R6 gate must match the channel
        wr(0, 2, 32'h0000_2000);
        exp_irq(1'b0, "R6 ch9 pending but gate on ch5 only");
        sync();
        wr(4, 0, 32'h0000_0200);
        exp_irq(1'b1, "R6 ch9 gated in");
        sync();

        // R8 bank 3, empty lanes, unused view codes
        wr(0, 3, 32'hFFFF_FFFF);
        exp_rd(0, 3, 32'h0, "R8 absent bank reads zero");
        exp_rd(0, 0, 32'h0, "R8 absent bank write not aliased");
        sync();
        wr(0, 2, 32'hFFFF_FFFF);
        exp_rd(0, 2, 32'h0000_3F3F, "R8 empty lanes read zero");
        exp_rd(5, 0, 32'h0, "R8 view code 5 reads zero");
        exp_rd(3, 2, 32'h0000_2000, "R5 masked bank2");
        sync();

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired (R1..R9 incomplete) actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule